// File: doc/BRIEF.md
# Linked-List Packet Queue Manager

This block manages a set of virtual packet queues that all draw on one shared pool of fixed-size buffers. Buffers are named by index. Each queue is a singly linked list of buffer indices. One next-pointer array is shared by all lists. A descriptor for each queue holds its head index, tail index and length. A separate list of free buffers is kept in local registers. It hands out a buffer on every enqueue and takes one back on every dequeue.

A client issues enqueue or dequeue commands that name a queue id, using a valid/ready handshake. For each command the block returns the buffer index it allocated or released, together with a status code. Payload storage and scheduling sit outside the block.

Each command takes two cycles. In the accept cycle the target descriptor is read into a holding register. The following cycle modifies that descriptor and the free list and writes them back.

Top module: `pkt_queue_mgr`

## Requirements
- R1: After reset `cmd_ready_o` is 1 and `rsp_valid_o` is 0. All buffers sit in the free list in ascending index order, so the first enqueues allocate buffers 0, 1, 2 and onward. Every virtual queue starts empty.
- R2: A command is accepted on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `cmd_ready_o` is 0 during the following cycle. The response is registered on the next rising edge, and `rsp_valid_o` stays high for exactly one cycle.
- R3: An enqueue (`cmd_op_i`=0) with a non-empty free list returns status 0 (ok). It returns the buffer at the head of the free list and appends that buffer to the tail of the named queue.
- R4: A dequeue (`cmd_op_i`=1) of a non-empty queue returns status 0 with the buffer at the head of that queue. Buffers leave each queue in the order they entered it.
- R5: A dequeued buffer is appended to the tail of the free list. It is allocated again only after every buffer that was already free.
- R6: An enqueue while the free list is empty returns status 1 (no buffer) and buffer index 0. It leaves every queue and the free list unchanged.
- R7: A dequeue of an empty queue returns status 2 (empty) and buffer index 0. It changes no state.
- R8: Commands to different queues may be interleaved in any order, and each queue keeps its own FIFO order.
- R9: A queue drained to empty and then refilled behaves as new: the first buffer enqueued becomes both its head and its tail.
- R10: While `cmd_valid_i` is 0 no command is executed and `rsp_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can accept a command |
| cmd_op_i | input | 1 | 0 = enqueue, 1 = dequeue |
| cmd_qid_i | input | QID_W | Target virtual queue |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_buf_o | output | BUF_W | Allocated or released buffer index, 0 on error |
| rsp_status_o | output | 2 | 0 ok, 1 no buffer, 2 queue empty |

## Verification
The bench keeps its own FIFO model of the free list and of every queue, and compares each returned index and status with that model. It drains a queue to empty and refills it. A design that left a stale head in place would return a buffer that was freed long before. It recycles buffers until the free list wraps, which exposes a design that pushes released buffers onto the head instead of the tail. It also exhausts the pool and then issues one more enqueue. A design that altered state on the failed enqueue would either leak a buffer or corrupt the head of the next dequeue.

// File: rtl/qm_pkg.sv
package qm_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_NOBUF = 2'd1,
    ST_EMPTY = 2'd2
  } status_e;

  typedef enum logic {
    OP_ENQ = 1'b0,
    OP_DEQ = 1'b1
  } op_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_EXEC = 1'b1
  } fsm_e;
endpackage

// File: rtl/qm_link_ram.sv
module qm_link_ram #(
  parameter int NUM_BUFS = 16,
  localparam int BW = $clog2(NUM_BUFS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] rd_a_addr_i,
  output logic [BW-1:0] rd_a_data_o,
  input  logic [BW-1:0] rd_b_addr_i,
  output logic [BW-1:0] rd_b_data_o,
  input  logic          we_i,
  input  logic [BW-1:0] waddr_i,
  input  logic [BW-1:0] wdata_i
);
  logic [BW-1:0] mem_q [NUM_BUFS];

  // reset chains every buffer to its successor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BUFS; i++) mem_q[i] <= BW'((i + 1) % NUM_BUFS);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rd_a_data_o = mem_q[rd_a_addr_i];
  assign rd_b_data_o = mem_q[rd_b_addr_i];
endmodule

// File: rtl/qm_desc_ram.sv
module qm_desc_ram #(
  parameter int NUM_BUFS   = 16,
  parameter int NUM_QUEUES = 8,
  localparam int BW = $clog2(NUM_BUFS),
  localparam int LW = $clog2(NUM_BUFS + 1),
  localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [QW-1:0] rd_qid_i,
  output logic [BW-1:0] rd_head_o,
  output logic [BW-1:0] rd_tail_o,
  output logic [LW-1:0] rd_len_o,
  input  logic          we_i,
  input  logic [QW-1:0] wr_qid_i,
  input  logic [BW-1:0] wr_head_i,
  input  logic [BW-1:0] wr_tail_i,
  input  logic [LW-1:0] wr_len_i
);
  logic [BW-1:0] head_q [NUM_QUEUES];
  logic [BW-1:0] tail_q [NUM_QUEUES];
  logic [LW-1:0] len_q  [NUM_QUEUES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_QUEUES; i++) begin
        head_q[i] <= '0;
        tail_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else if (we_i) begin
      head_q[wr_qid_i] <= wr_head_i;
      tail_q[wr_qid_i] <= wr_tail_i;
      len_q[wr_qid_i]  <= wr_len_i;
    end
  end

  assign rd_head_o = head_q[rd_qid_i];
  assign rd_tail_o = tail_q[rd_qid_i];
  assign rd_len_o  = len_q[rd_qid_i];
endmodule

// File: rtl/qm_free_list.sv
module qm_free_list #(
  parameter int NUM_BUFS = 16,
  localparam int BW = $clog2(NUM_BUFS),
  localparam int LW = $clog2(NUM_BUFS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic [BW-1:0] pop_next_i,
  input  logic          push_i,
  input  logic [BW-1:0] push_buf_i,
  output logic [BW-1:0] head_o,
  output logic [BW-1:0] tail_o,
  output logic [LW-1:0] len_o
);
  logic [BW-1:0] head_q, tail_q;
  logic [LW-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= BW'(NUM_BUFS - 1);
      len_q  <= LW'(NUM_BUFS);
    end else if (pop_i) begin
      head_q <= pop_next_i;
      len_q  <= len_q - LW'(1);
    end else if (push_i) begin
      if (len_q == '0) head_q <= push_buf_i;
      tail_q <= push_buf_i;
      len_q  <= len_q + LW'(1);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign len_o  = len_q;
endmodule

// File: rtl/pkt_queue_mgr.sv
module pkt_queue_mgr
  import qm_pkg::*;
#(
  parameter int NUM_BUFS   = 16,
  parameter int NUM_QUEUES = 8,
  localparam int BUF_W = $clog2(NUM_BUFS),
  localparam int LEN_W = $clog2(NUM_BUFS + 1),
  localparam int QID_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic             cmd_op_i,
  input  logic [QID_W-1:0] cmd_qid_i,
  output logic             rsp_valid_o,
  output logic [BUF_W-1:0] rsp_buf_o,
  output logic [1:0]       rsp_status_o
);
  fsm_e             state_q;
  op_e              op_q;
  logic [QID_W-1:0] qid_q;
  logic [BUF_W-1:0] vq_head_q, vq_tail_q;
  logic [LEN_W-1:0] vq_len_q;

  logic [BUF_W-1:0] rd_head, rd_tail;
  logic [LEN_W-1:0] rd_len;

  logic [BUF_W-1:0] free_head, free_tail;
  logic [LEN_W-1:0] free_len;
  logic [BUF_W-1:0] free_next, vq_next;

  logic             exec, accept, ok, fl_pop, fl_push;
  logic             lk_we, dq_we;
  logic [BUF_W-1:0] lk_waddr, lk_wdata, buf_sel;
  logic [BUF_W-1:0] dq_head, dq_tail;
  logic [LEN_W-1:0] dq_len;
  status_e          status;

  logic             rsp_valid_q;
  logic [BUF_W-1:0] rsp_buf_q;
  status_e          rsp_status_q;

  assign exec        = (state_q == S_EXEC);
  assign cmd_ready_o = (state_q == S_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;

  qm_desc_ram #(.NUM_BUFS(NUM_BUFS), .NUM_QUEUES(NUM_QUEUES)) i_desc (
    .clk_i, .rst_ni,
    .rd_qid_i (cmd_qid_i),
    .rd_head_o(rd_head),
    .rd_tail_o(rd_tail),
    .rd_len_o (rd_len),
    .we_i     (dq_we),
    .wr_qid_i (qid_q),
    .wr_head_i(dq_head),
    .wr_tail_i(dq_tail),
    .wr_len_i (dq_len)
  );

  qm_link_ram #(.NUM_BUFS(NUM_BUFS)) i_link (
    .clk_i, .rst_ni,
    .rd_a_addr_i(free_head),
    .rd_a_data_o(free_next),
    .rd_b_addr_i(vq_head_q),
    .rd_b_data_o(vq_next),
    .we_i       (lk_we),
    .waddr_i    (lk_waddr),
    .wdata_i    (lk_wdata)
  );

  qm_free_list #(.NUM_BUFS(NUM_BUFS)) i_free (
    .clk_i, .rst_ni,
    .pop_i     (fl_pop),
    .pop_next_i(free_next),
    .push_i    (fl_push),
    .push_buf_i(vq_head_q),
    .head_o    (free_head),
    .tail_o    (free_tail),
    .len_o     (free_len)
  );

  // read phase: capture descriptor at accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= OP_ENQ;
      qid_q     <= '0;
      vq_head_q <= '0;
      vq_tail_q <= '0;
      vq_len_q  <= '0;
    end else if (accept) begin
      state_q   <= S_EXEC;
      op_q      <= op_e'(cmd_op_i);
      qid_q     <= cmd_qid_i;
      vq_head_q <= rd_head;
      vq_tail_q <= rd_tail;
      vq_len_q  <= rd_len;
    end else begin
      state_q   <= S_IDLE;
    end
  end

  // modify/write phase
  always_comb begin
    ok       = 1'b0;
    fl_pop   = 1'b0;
    fl_push  = 1'b0;
    lk_we    = 1'b0;
    lk_waddr = '0;
    lk_wdata = '0;
    dq_we    = 1'b0;
    dq_head  = vq_head_q;
    dq_tail  = vq_tail_q;
    dq_len   = vq_len_q;
    buf_sel  = '0;
    status   = ST_OK;
    if (op_q == OP_ENQ) begin
      ok      = (free_len != '0);
      status  = ok ? ST_OK : ST_NOBUF;
      buf_sel = free_head;
      if (exec && ok) begin
        fl_pop   = 1'b1;
        dq_we    = 1'b1;
        dq_head  = (vq_len_q == '0) ? free_head : vq_head_q;
        dq_tail  = free_head;
        dq_len   = vq_len_q + LEN_W'(1);
        lk_we    = (vq_len_q != '0);
        lk_waddr = vq_tail_q;
        lk_wdata = free_head;
      end
    end else begin
      ok      = (vq_len_q != '0);
      status  = ok ? ST_OK : ST_EMPTY;
      buf_sel = vq_head_q;
      if (exec && ok) begin
        fl_push  = 1'b1;
        dq_we    = 1'b1;
        dq_head  = vq_next;
        dq_len   = vq_len_q - LEN_W'(1);
        lk_we    = (free_len != '0);
        lk_waddr = free_tail;
        lk_wdata = vq_head_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_buf_q    <= '0;
      rsp_status_q <= ST_OK;
    end else begin
      rsp_valid_q <= exec;
      if (exec) begin
        rsp_buf_q    <= ok ? buf_sel : '0;
        rsp_status_q <= status;
      end
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_buf_o    = rsp_buf_q;
  assign rsp_status_o = rsp_status_q;
endmodule

// File: rtl/qm_checker.sv
module qm_checker #(
  parameter int NUM_BUFS   = 16,
  parameter int NUM_QUEUES = 8,
  localparam int BUF_W = $clog2(NUM_BUFS),
  localparam int LEN_W = $clog2(NUM_BUFS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic             rsp_valid_o,
  input logic [BUF_W-1:0] rsp_buf_o,
  input logic [1:0]       rsp_status_o,
  input logic [LEN_W-1:0] free_len
);
  a_r2_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o);

  a_r2_rsp_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> ##1 rsp_valid_o);

  a_r2_rsp_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r10_no_rsp_without_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_ready_o) |=> ##1 !rsp_valid_o);

  a_r6_nobuf_only_when_dry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_status_o == 2'd1 |-> free_len == '0);

  a_r7_error_buf_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_status_o != 2'd0 |-> rsp_buf_o == '0);

  a_r5_free_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_len <= LEN_W'(NUM_BUFS));
endmodule

bind pkt_queue_mgr qm_checker #(.NUM_BUFS(NUM_BUFS), .NUM_QUEUES(NUM_QUEUES)) i_qm_checker (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .rsp_valid_o, .rsp_buf_o, .rsp_status_o,
  .free_len
);

// File: tb/test_pkt_queue_mgr.sv
`timescale 1ns/1ps
module test_pkt_queue_mgr;
  localparam int NB = 16;
  localparam int NQ = 8;
  localparam int BW = $clog2(NB);
  localparam int QW = $clog2(NQ);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic          cmd_op_i = 1'b0;
  logic [QW-1:0] cmd_qid_i = '0;
  logic          rsp_valid_o;
  logic [BW-1:0] rsp_buf_o;
  logic [1:0]    rsp_status_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int free_m[$];
  int vq_m[NQ][$];

  always #4 clk_i = ~clk_i;

  pkt_queue_mgr #(.NUM_BUFS(NB), .NUM_QUEUES(NQ)) i_pkt_queue_mgr (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue one command, compare with the FIFO model, update the model
  task automatic run_op(bit op, int q, string req);
    int eb, es;
    int ab, as_;
    if (op == 1'b0) begin
      if (free_m.size() == 0) begin eb = 0; es = 1; end
      else begin eb = free_m.pop_front(); es = 0; vq_m[q].push_back(eb); end
    end else begin
      if (vq_m[q].size() == 0) begin eb = 0; es = 2; end
      else begin eb = vq_m[q].pop_front(); es = 0; free_m.push_back(eb); end
    end
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_qid_i   = QW'(q);
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    check("R2 ready low after accept", int'(cmd_ready_o), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R2 rsp valid", int'(rsp_valid_o), 1);
    ab  = int'(rsp_buf_o);
    as_ = int'(rsp_status_o);
    check({req, " buffer"}, ab, eb);
    check({req, " status"}, as_, es);
    @(negedge clk_i);
    check("R2 rsp one cycle", int'(rsp_valid_o), 0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R1 ready after reset", int'(cmd_ready_o), 1);
    check("R1 no rsp after reset", int'(rsp_valid_o), 0);
  endtask

  task automatic t_idle;
    cmd_valid_i = 1'b0;
    cmd_op_i    = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      check("R10 idle no rsp", int'(rsp_valid_o), 0);
    end
  endtask

  task automatic t_first_alloc;
    for (int i = 0; i < 3; i++) run_op(1'b0, 0, "R1 R3 enqueue in index order");
  endtask

  task automatic t_fifo_drain;
    for (int i = 0; i < 3; i++) run_op(1'b1, 0, "R4 dequeue fifo order");
    run_op(1'b1, 0, "R7 dequeue empty");
    run_op(1'b1, 5, "R7 dequeue never used queue");
  endtask

  task automatic t_refill;
    run_op(1'b0, 0, "R9 refill head");
    run_op(1'b1, 0, "R9 refill single out");
    run_op(1'b1, 0, "R9 empty again");
  endtask

  task automatic t_recycle;
    for (int i = 0; i < 14; i++) run_op(1'b0, 1, "R5 recycle order");
    for (int i = 0; i < 14; i++) run_op(1'b1, 1, "R5 release to tail");
  endtask

  task automatic t_interleave;
    for (int i = 0; i < 12; i++) run_op(1'b0, i % 4, "R8 interleave enqueue");
    for (int i = 0; i < 12; i++) run_op(1'b1, (i * 3) % 4, "R8 interleave dequeue");
  endtask

  task automatic t_exhaust;
    for (int i = 0; i < NB; i++) run_op(1'b0, 7 - (i % 2), "R3 fill pool");
    run_op(1'b0, 2, "R6 no buffer");
    run_op(1'b0, 7, "R6 no buffer again");
    run_op(1'b1, 7, "R6 state unchanged head");
    run_op(1'b0, 3, "R6 recovered alloc");
    for (int i = 0; i < NB; i++) run_op(1'b1, 6 + (i % 2), "R4 drain after exhaust");
  endtask

  initial begin
    for (int i = 0; i < NB; i++) free_m.push_back(i);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_idle();
    t_first_alloc();
    t_fifo_drain();
    t_refill();
    t_recycle();
    t_interleave();
    t_exhaust();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule